// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block answers the SMBus alert response poll for a device that holds a pending threshold alert. It samples the two I2C lines through its own synchronizers and decodes START, STOP and the SCL edges. It then watches the first byte after every START. When that byte is the alert response read (0x19) and the device has an alert pending with interrupt mode on, it pulls SDA low for the acknowledge. It then returns its 7-bit device address with a cause bit appended.

Several devices may answer the same poll, so every bit the responder leaves released is compared with the bus at the SCL rising edge. A responder that finds the line low after it released it has lost. It stops driving for the rest of the byte and keeps its alert pending. A responder that sends the whole byte without losing raises a one-cycle clear strobe once the master's acknowledge clock has ended. An interface-mode input also decides whether a pending alert drives a separate active-low open-drain alert line or is only reported through polling.

Top module: `smbar_resp`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sda_pull`, `alert_clr` and `alert_pin_pull` are all 0.
- R2: The responder acknowledges only the first byte after a START that equals 0x19, sent MSB first (address 0001100, R/W bit 1). Any other byte, including 0x18 (the same address with a write), leaves SDA released for the whole transfer.
- R3: The 0x19 byte is acknowledged (SDA pulled low during the ninth clock) only when both `alert_pend` and `irq_mode` are 1. Otherwise the responder stays off the bus.
- R4: After the acknowledge, the responder sends `own_addr` MSB first, followed by the cause bit. For each bit it pulls SDA low exactly when that bit is 0, and it changes SDA only while SCL is low.
- R5: The cause bit (LSB of the returned byte) equals `alert_high`: 1 for a high-threshold alert and 0 for a low-threshold alert.
- R6: If the responder releases SDA for a 1 but samples 0 at an SCL rising edge, it has lost arbitration. It releases SDA for every remaining bit of that byte.
- R7: After a byte sent without any loss, `alert_clr` pulses high for exactly one cycle at the falling SCL edge that ends the master's acknowledge bit.
- R8: After a loss, including a loss on the cause bit, `alert_clr` stays 0 for that poll.
- R9: `alert_pin_pull` is 1 one cycle after `pin_mode`, `alert_pend` and `irq_mode` are all 1. It is 0 one cycle after any of them is 0.
- R10: A START or STOP in the middle of a response aborts it. SDA is released and no clear strobe is given, and a later complete poll is answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| alert_pend | input | 1 | Threshold alert pending |
| alert_high | input | 1 | Alert cause: 1 high threshold, 0 low threshold |
| irq_mode | input | 1 | Interrupt mode enable; polls are answered only when 1 |
| pin_mode | input | 1 | 1: a pending alert also drives the alert line |
| own_addr | input | 7 | Device address returned in the response |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| alert_clr | output | 1 | One-cycle strobe that clears the pending alert |
| alert_pin_pull | output | 1 | 1 pulls the active-low alert line low |

## Verification
Loss detection and byte completion can fall on the same bit. When the cause bit is the only bit that differs from a competitor, the loss is recorded at the eighth rising edge. The decision to clear is then taken at the very next falling edge of the acknowledge clock. The bench provokes this with a modelled competitor whose byte equals the responder's address with cause 0 while the responder sends cause 1. It expects SDA released on that bit and no clear strobe. The mirror case, where the responder holds the 0 and wins on that bit, must still produce exactly one strobe.

// File: rtl/smbar_pkg.sv
package smbar_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_TX,
      ST_MACK
   } resp_state_e;
endpackage

// File: rtl/smbar_sync.sv
module smbar_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smbar_events.sv
module smbar_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbar_engine.sv
module smbar_engine
   import smbar_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 7,
   parameter logic [BYTE_W-1:0] ARA_CODE = 8'h19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_c,
   input  logic              stop_c,
   input  logic              sda_s,
   input  logic              go,
   input  logic              cause_high,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              sda_pull,
   output logic              alert_clr,
   output logic              lost_o,
   output logic              ack_o
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   resp_state_e       state;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              pull_q, lost_q, clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         shreg  <= '0;
         cnt    <= '0;
         pull_q <= 1'b0;
         lost_q <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         if (start_c) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            pull_q <= 1'b0;
            lost_q <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     if (shreg == ARA_CODE && go) begin
                        state  <= ST_ACK;
                        pull_q <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state  <= ST_TX;
                     shreg  <= {own_addr, cause_high};
                     pull_q <= ~own_addr[ADDR_W-1];
                     cnt    <= '0;
                     lost_q <= 1'b0;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                     if (!pull_q && !sda_s) lost_q <= 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST) begin
                        state  <= ST_MACK;
                        pull_q <= 1'b0;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        pull_q <= ~shreg[BYTE_W-2] & ~lost_q;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_fall) begin
                     clr_q <= ~lost_q;
                     state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_pull  = pull_q;
   assign alert_clr = clr_q;
   assign lost_o    = lost_q;
   assign ack_o     = (state == ST_ACK);
endmodule

// File: rtl/smbar_resp.sv
module smbar_resp
   import smbar_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 7,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] ARA_CODE    = 8'h19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              alert_pend,
   input  logic              alert_high,
   input  logic              irq_mode,
   input  logic              pin_mode,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              sda_pull,
   output logic              alert_clr,
   output logic              alert_pin_pull
);
   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must be one less than the byte width");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_c, stop_c;
   logic lost_w, ack_w;
   logic pin_q;

   smbar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   smbar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   smbar_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   smbar_engine #(.ADDR_W(ADDR_W), .ARA_CODE(ARA_CODE)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c), .sda_s(sda_s),
      .go(alert_pend & irq_mode), .cause_high(alert_high),
      .own_addr(own_addr),
      .sda_pull(sda_pull), .alert_clr(alert_clr),
      .lost_o(lost_w), .ack_o(ack_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_mode & alert_pend & irq_mode;
   end
   assign alert_pin_pull = pin_q;
endmodule

// File: rtl/smbar_chk.sv
module smbar_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic alert_pend,
   input logic irq_mode,
   input logic pin_mode,
   input logic sda_pull,
   input logic alert_clr,
   input logic alert_pin_pull,
   input logic lost,
   input logic in_ack
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!sda_pull && !alert_clr && !alert_pin_pull));

   p_ack_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> (alert_pend && irq_mode));

   p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_in);

   p_release_after_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> !$rose(sda_pull));

   p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alert_clr |=> !alert_clr);

   p_no_clr_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alert_clr |-> $past(!lost));

   p_pin_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode && alert_pend && irq_mode) |=> alert_pin_pull);

   p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_mode |=> !alert_pin_pull);
endmodule

bind smbar_resp smbar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
   .alert_pend(alert_pend), .irq_mode(irq_mode), .pin_mode(pin_mode),
   .sda_pull(sda_pull), .alert_clr(alert_clr),
   .alert_pin_pull(alert_pin_pull),
   .lost(lost_w), .in_ack(ack_w));

// File: tb/smbar_resp_bench.sv
module smbar_resp_bench;
   localparam int Q  = 8;
   localparam int NV = 11;
   // {code[26:19], pend[18], irq[17], high[16], pin[15], own[14:8], comp[7:0]}
   localparam logic [26:0] VEC [NV] = '{
      {8'h19, 1'b1, 1'b1, 1'b1, 1'b0, 7'h48, 8'hFF},
      {8'h19, 1'b1, 1'b1, 1'b0, 1'b1, 7'h2D, 8'hFF},
      {8'h19, 1'b0, 1'b1, 1'b1, 1'b1, 7'h48, 8'hFF},
      {8'h19, 1'b1, 1'b0, 1'b1, 1'b1, 7'h48, 8'hFF},
      {8'h18, 1'b1, 1'b1, 1'b1, 1'b0, 7'h48, 8'hFF},
      {8'h98, 1'b1, 1'b1, 1'b1, 1'b1, 7'h48, 8'hFF},
      {8'h19, 1'b1, 1'b1, 1'b1, 1'b0, 7'h48, 8'h20},
      {8'h19, 1'b1, 1'b1, 1'b1, 1'b0, 7'h48, 8'h90},
      {8'h19, 1'b1, 1'b1, 1'b0, 1'b0, 7'h48, 8'h91},
      {8'h19, 1'b1, 1'b1, 1'b1, 1'b1, 7'h7F, 8'hFF},
      {8'h19, 1'b1, 1'b1, 1'b0, 1'b0, 7'h00, 8'hFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, m_sda = 1'b1, comp_pull = 1'b0;
   logic alert_pend = 1'b0, alert_high = 1'b0, irq_mode = 1'b0, pin_mode = 1'b0;
   logic [6:0] own_addr = 7'h0;
   logic sda_pull, alert_clr, alert_pin_pull;
   logic sda_bus;
   int nchk = 0, nerr = 0, clr_seen = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull & ~comp_pull;

   smbar_resp u_smbar_resp (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
      .alert_pend(alert_pend), .alert_high(alert_high),
      .irq_mode(irq_mode), .pin_mode(pin_mode), .own_addr(own_addr),
      .sda_pull(sda_pull), .alert_clr(alert_clr),
      .alert_pin_pull(alert_pin_pull));

   always @(posedge clk) if (alert_clr === 1'b1) clr_seen <= clr_seen + 1;

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic drv, input logic cdrv, output logic smp, output logic dp);
      scl = 1'b0; wt(Q);
      m_sda = drv; comp_pull = cdrv; wt(Q);
      scl = 1'b1; wt(Q);
      smp = sda_bus; dp = sda_pull; wt(Q);
   endtask

   task automatic start_cond();
      scl = 1'b1; m_sda = 1'b1; wt(Q);
      m_sda = 1'b0; wt(Q);
   endtask

   task automatic stop_cond();
      scl = 1'b0; wt(Q);
      m_sda = 1'b0; comp_pull = 1'b0; wt(Q);
      scl = 1'b1; wt(Q);
      m_sda = 1'b1; wt(Q);
   endtask

   task automatic send_addr(input logic [7:0] code, output logic ackp);
      logic s, d;
      start_cond();
      for (int b = 7; b >= 0; b--) clk_bit(code[b], 1'b0, s, d);
      clk_bit(1'b1, 1'b0, s, ackp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] code, comp, myb, rx, opat, epat;
      logic pend, irq, high, pin, exp_ack, ackp, mylost, clost, mye, s, d;
      int base;

      wt(3);
      chk(sda_pull == 1'b0, "R1 sda_pull in reset", sda_pull, 0);
      chk(alert_clr == 1'b0, "R1 alert_clr in reset", alert_clr, 0);
      chk(alert_pin_pull == 1'b0, "R1 alert pin in reset", alert_pin_pull, 0);
      rst_n = 1'b1; wt(4);

      for (int v = 0; v < NV; v++) begin
         {code, pend, irq, high, pin, own_addr, comp} = VEC[v];
         alert_pend = pend; irq_mode = irq; alert_high = high; pin_mode = pin;
         wt(4);
         chk(alert_pin_pull == (pin & pend & irq), "R9 alert pin level",
             alert_pin_pull, pin & pend & irq);
         exp_ack = (code == 8'h19) && pend && irq;
         base = clr_seen;
         send_addr(code, ackp);
         chk(ackp == exp_ack, "R2/R3 acknowledge", ackp, exp_ack);
         myb = {own_addr, high};
         mylost = 1'b0; clost = 1'b0;
         for (int b = 7; b >= 0; b--) begin
            mye = mylost ? 1'b1 : myb[b];
            epat[b] = exp_ack && !mye;
            clk_bit(1'b1, !comp[b] && !clost, s, d);
            opat[b] = d; rx[b] = s;
            if (exp_ack && !mylost && myb[b] && !s) mylost = 1'b1;
            if (comp[b] && !s) clost = 1'b1;
         end
         clk_bit(1'b0, 1'b0, s, d);
         stop_cond(); wt(4);
         chk(opat == epat, "R4/R6 SDA drive pattern", opat, epat);
         if (exp_ack && comp == 8'hFF)
            chk(rx == myb, "R5 returned address and cause bit", rx, myb);
         chk((clr_seen - base) == int'(exp_ack && !mylost), "R7/R8 clear strobe count",
             clr_seen - base, int'(exp_ack && !mylost));
      end

      // R10: repeated START right after the acknowledge
      own_addr = 7'h48; alert_high = 1'b1; alert_pend = 1'b1; irq_mode = 1'b1; pin_mode = 1'b0;
      base = clr_seen;
      send_addr(8'h19, ackp);
      chk(ackp == 1'b1, "R10 setup ack", ackp, 1);
      scl = 1'b0; wt(Q); wt(Q);
      scl = 1'b1; wt(Q);
      m_sda = 1'b0; wt(Q);
      chk(sda_pull == 1'b0, "R10 released after repeated START", sda_pull, 0);
      for (int b = 7; b >= 0; b--) clk_bit(1'b1, 1'b0, s, d);
      clk_bit(1'b1, 1'b0, s, d);
      chk(d == 1'b0, "R10 no ack of 0xFF after restart", d, 0);
      stop_cond(); wt(4);
      chk(clr_seen == base, "R10 no clear after restart abort", clr_seen - base, 0);

      // R10: STOP in the first data bit
      base = clr_seen;
      send_addr(8'h19, ackp);
      stop_cond(); wt(4);
      chk(sda_pull == 1'b0, "R10 released after STOP", sda_pull, 0);
      chk(clr_seen == base, "R10 no clear after STOP abort", clr_seen - base, 0);

      // R10: full poll afterwards still works
      base = clr_seen;
      send_addr(8'h19, ackp);
      for (int b = 7; b >= 0; b--) begin
         clk_bit(1'b1, 1'b0, s, d);
         rx[b] = s;
      end
      clk_bit(1'b0, 1'b0, s, d);
      stop_cond(); wt(4);
      chk(rx == 8'h91, "R10 poll after abort returns byte", rx, 8'h91);
      chk(clr_seen - base == 1, "R10 poll after abort clears", clr_seen - base, 1);

      // R9: pin follows interface mode and interrupt mode
      pin_mode = 1'b1; wt(3);
      chk(alert_pin_pull == 1'b1, "R9 pin asserted", alert_pin_pull, 1);
      irq_mode = 1'b0; wt(3);
      chk(alert_pin_pull == 1'b0, "R9 pin off with interrupt mode off", alert_pin_pull, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule